// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block sits in front of a hash engine's data path. It turns one command into a sequence of (address, length) segment requests for a downstream data fetcher. In list mode it reads an in-memory chain of 8-byte descriptors starting at a programmed base. Each descriptor holds a length word followed by an address word. The walker fetches them through a 32-bit read port that has a single outstanding request, and it emits one segment per descriptor. It stops at the descriptor whose length word carries the final flag.

While walking, the block adds up the segment lengths and compares the sum with a programmed expected total. It also enforces a cap on how many descriptors it will visit, and it aborts if a descriptor read returns an error. In direct mode it emits a single contiguous segment taken straight from the programmed source address and length. Completion and the error conditions are reported as status levels, and an interrupt output follows completion when the command enabled it.

Top module: `sg_list_walker`

## Requirements
- R1: In list mode, descriptor i is read as two words: the length word at B + 8*i, then the address word at B + 8*i + 4. B is `src_addr & 32'h7FFF_FFF8`. A read is a one-cycle `mem_req` pulse, and no new request is issued until `mem_valid` has returned for the previous one.
- R2: The segment length is bits [30:0] of the length word. Bit 31 of that word marks the final descriptor: its segment has `seg_last`=1, and no further descriptor is read after it.
- R3: In list mode the segment address is the address word ANDed with `32'h7FFF_FFF8`, so bits [2:0] and bit 31 are zero.
- R4: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len` and `seg_last` hold their values.
- R5: If MAX_ENTRIES segments are accepted and none of them was final, the walk stops with `err_overflow`=1 and `done`=0.
- R6: When the final segment is accepted, `done` is set. `len_mismatch` is set if the sum of all segment lengths differs from `src_len` as sampled at the command.
- R7: A command with bit 18 clear selects direct mode. It emits exactly one segment with `seg_addr`=`src_addr` unmasked, `seg_len`=`src_len[30:0]` and `seg_last`=1. It issues no memory reads, and on acceptance it sets `done` with `len_mismatch`=0.
- R8: `done` is set on completion whether or not interrupts are enabled. `irq` is high exactly while `done` is high and bit 9 of the starting command was set.
- R9: A descriptor read that returns `mem_err` ends the walk with `err_access`=1 and `done`=0. No segment is emitted for that descriptor, and no further reads are issued.
- R10: A `cmd_wr` while `busy` is high is ignored, including any change to the sampled base and total. A `done_clr` pulse clears `done` and with it `irq`. A new command clears `done`, `len_mismatch` and both error flags.
- R11: After reset, `busy`, `seg_valid`, `mem_req`, `done`, `irq`, `len_mismatch`, `err_access` and `err_overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 32 | Command word; bit 18 selects list mode, bit 9 enables the interrupt |
| src_addr | input | 32 | List base (list mode) or data address (direct mode) |
| src_len | input | 32 | Expected total length (list) or segment length (direct) |
| done_clr | input | 1 | Write-one-to-clear pulse for `done` |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor read byte address |
| mem_valid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data, little-endian word |
| mem_err | input | 1 | Read response error, qualified by `mem_valid` |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Segment consumer ready |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 31 | Segment length in bytes |
| seg_last | output | 1 | Segment is the final one of the command |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completed successfully |
| len_mismatch | output | 1 | Summed length differed from the expected total |
| err_access | output | 1 | Walk aborted by a read error |
| err_overflow | output | 1 | Walk aborted by the descriptor cap |
| irq | output | 1 | Completion interrupt |

## Verification
Some properties are checked by assertions on every cycle. Reads never overlap. Segments stay stable under backpressure. List-mode addresses come out aligned with bit 31 clear. Direct mode never touches memory. `irq` never appears without `done`, and neither error flag is ever set together with `done`. Other behaviour needs the bench's scenarios: the exact descriptor address sequence, the field extraction, the point where the walk stops (final flag, cap, or an error on any of the six reads), the summed-length comparison, and the ignoring of a mid-walk command. These depend on memory contents and arithmetic that only scenario-level expected values can capture.

// File: rtl/sg_list_walker.sv
module sg_list_walker #(
  parameter int MAX_ENTRIES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_data,
  input  logic [31:0] src_addr,
  input  logic [31:0] src_len,
  input  logic        done_clr,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        seg_valid,
  input  logic        seg_ready,
  output logic [31:0] seg_addr,
  output logic [30:0] seg_len,
  output logic        seg_last,
  output logic        busy,
  output logic        done,
  output logic        len_mismatch,
  output logic        err_access,
  output logic        err_overflow,
  output logic        irq
);
  localparam int CW = $clog2(MAX_ENTRIES + 1);
  localparam int SW = 31 + CW;
  localparam logic [31:0] AMASK = 32'h7FFF_FFF8;

  typedef enum logic [2:0] {S_IDLE, S_REQ_LEN, S_WAIT_LEN, S_REQ_ADR, S_WAIT_ADR, S_SEG} st_t;

  st_t          st;
  logic [31:0]  base, total;
  logic [CW-1:0] idx;
  logic [SW-1:0] sum;
  logic         sg_mode, ien;

  wire [SW-1:0] sum_next = sum + SW'(seg_len);
  wire [CW-1:0] idx_next = idx + CW'(1);

  logic unused_bits;
  assign unused_bits = ^{cmd_data[31:19], cmd_data[17:10], cmd_data[8:0]};

  assign busy      = (st != S_IDLE);
  assign seg_valid = (st == S_SEG);
  assign mem_req   = (st == S_REQ_LEN) || (st == S_REQ_ADR);
  assign mem_addr  = base + (32'(idx) << 3) + ((st == S_REQ_ADR) ? 32'd4 : 32'd0);
  assign irq       = done & ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base <= '0;
      total <= '0;
      idx <= '0;
      sum <= '0;
      sg_mode <= 1'b0;
      ien <= 1'b0;
      seg_addr <= '0;
      seg_len <= '0;
      seg_last <= 1'b0;
      done <= 1'b0;
      len_mismatch <= 1'b0;
      err_access <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      if (done_clr) done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_wr) begin
          ien <= cmd_data[9];
          sg_mode <= cmd_data[18];
          done <= 1'b0;
          len_mismatch <= 1'b0;
          err_access <= 1'b0;
          err_overflow <= 1'b0;
          total <= src_len;
          base <= src_addr & AMASK;
          idx <= '0;
          sum <= '0;
          if (cmd_data[18]) st <= S_REQ_LEN;
          else begin
            seg_addr <= src_addr;
            seg_len <= src_len[30:0];
            seg_last <= 1'b1;
            st <= S_SEG;
          end
        end
        S_REQ_LEN: st <= S_WAIT_LEN;
        S_WAIT_LEN: if (mem_valid) begin
          if (mem_err) begin
            err_access <= 1'b1;
            st <= S_IDLE;
          end else begin
            seg_len <= mem_rdata[30:0];
            seg_last <= mem_rdata[31];
            st <= S_REQ_ADR;
          end
        end
        S_REQ_ADR: st <= S_WAIT_ADR;
        S_WAIT_ADR: if (mem_valid) begin
          if (mem_err) begin
            err_access <= 1'b1;
            st <= S_IDLE;
          end else begin
            seg_addr <= mem_rdata & AMASK;
            st <= S_SEG;
          end
        end
        S_SEG: if (seg_ready) begin
          sum <= sum_next;
          if (seg_last) begin
            done <= 1'b1;
            len_mismatch <= sg_mode && (64'(sum_next) != 64'(total));
            st <= S_IDLE;
          end else if (idx_next == CW'(MAX_ENTRIES)) begin
            err_overflow <= 1'b1;
            st <= S_IDLE;
          end else begin
            idx <= idx_next;
            st <= S_REQ_LEN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_seg_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && sg_mode) |-> ((seg_addr & ~AMASK) == 32'd0));
  assert_seg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last)));
  assert_no_mem_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> sg_mode);
  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  assert_err_excludes_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_access || err_overflow) |-> !done);
endmodule

// File: tb/sg_list_walker_bench.sv
`timescale 1ns/1ps
module sg_list_walker_bench;
  localparam int MAXE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, done_clr = 1'b0;
  logic [31:0] cmd_data = '0, src_addr = '0, src_len = '0;
  logic mem_req, mem_valid = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic seg_valid, seg_ready = 1'b0, seg_last;
  logic [31:0] seg_addr;
  logic [30:0] seg_len;
  logic busy, done, len_mismatch, err_access, err_overflow, irq;

  sg_list_walker #(.MAX_ENTRIES(MAXE)) u_sg_list_walker (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .src_addr(src_addr), .src_len(src_len), .done_clr(done_clr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_last(seg_last), .busy(busy), .done(done), .len_mismatch(len_mismatch),
    .err_access(err_access), .err_overflow(err_overflow), .irq(irq));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [0:63];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] raddr = '0;
  int lat = 0, rpat = 0, rcnt = 0;

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    mem_err <= 1'b0;
    if (lat == 1) begin
      mem_valid <= 1'b1;
      mem_rdata <= mem[raddr[7:2]];
      mem_err <= (raddr == err_addr);
    end
    if (lat > 0) lat <= lat - 1;
    if (mem_req) begin
      lat <= 2;
      raddr <= mem_addr;
    end
    rcnt <= rcnt + 1;
    seg_ready <= (rpat == 0) || ((rcnt % (rpat + 1)) == 0);
  end

  logic [31:0] sl_addr [0:63];
  logic [30:0] sl_len [0:63];
  logic        sl_last [0:63];
  logic [31:0] rl_addr [0:63];
  int n_seg = 0, n_rd = 0;

  always @(negedge clk) if (rst_n) begin
    if (seg_valid && seg_ready) begin
      sl_addr[n_seg % 64] <= seg_addr;
      sl_len[n_seg % 64] <= seg_len;
      sl_last[n_seg % 64] <= seg_last;
      n_seg <= n_seg + 1;
    end
    if (mem_req) begin
      rl_addr[n_rd % 64] <= mem_addr;
      n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(int i);
    return (i + 1) * 16 + 3;
  endfunction

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 400) begin @(negedge clk); t++; end
    chk(!busy, "R1 walk terminates", 64'(busy), 64'd0);
    @(negedge clk);
  endtask

  task automatic run_sg(int last_pos, logic [31:0] base_raw, int extra, bit ien,
                        int err_read, int pat, bit poke);
    logic [31:0] bm;
    int wb, nent, nseg, nrd, s0, r0, sum;
    bit exp_done, exp_ovf;
    bm = base_raw & 32'h7FFF_FFF8;
    wb = int'(bm >> 2);
    for (int i = 0; i < MAXE; i++) begin
      mem[wb + 2*i] = 32'(len_of(i)) | ((i == last_pos) ? 32'h8000_0000 : 32'h0);
      mem[wb + 2*i + 1] = 32'h8000_1005 + 32'(i) * 32'h100;
    end
    nent = (last_pos < 0) ? MAXE : last_pos + 1;
    sum = 0;
    for (int i = 0; i < nent; i++) sum += len_of(i);
    err_addr = (err_read >= 0) ? bm + 32'(4 * err_read) : 32'hFFFF_FFFF;
    nseg = (err_read >= 0) ? err_read / 2 : nent;
    nrd = (err_read >= 0) ? err_read + 1 : 2 * nent;
    exp_done = (err_read < 0) && (last_pos >= 0);
    exp_ovf = (err_read < 0) && (last_pos < 0);
    rpat = pat;
    s0 = n_seg;
    r0 = n_rd;
    src_addr = base_raw;
    src_len = 32'(sum + extra);
    cmd_data = 32'h0004_0000 | (ien ? 32'h200 : 32'h0);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      cmd_data = 32'h0;
      src_addr = 32'h5;
      src_len = 32'h7;
      cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
    end
    wait_idle();
    chk(n_seg - s0 == nseg, poke ? "R10 busy command ignored, segment count" : "R2 segment count",
        64'(n_seg - s0), 64'(nseg));
    chk(n_rd - r0 == nrd, err_read >= 0 ? "R9 read count after error" : "R1 read count",
        64'(n_rd - r0), 64'(nrd));
    for (int k = 0; k < nseg && k < n_seg - s0; k++) begin
      chk(sl_addr[(s0+k)%64] == 32'h1000 + 32'(k) * 32'h100, "R3 segment address",
          64'(sl_addr[(s0+k)%64]), 64'(32'h1000 + 32'(k) * 32'h100));
      chk(sl_len[(s0+k)%64] == 31'(len_of(k)), "R2 segment length",
          64'(sl_len[(s0+k)%64]), 64'(len_of(k)));
      chk(sl_last[(s0+k)%64] == (k == last_pos), "R2 last marker",
          64'(sl_last[(s0+k)%64]), 64'(k == last_pos));
    end
    for (int j = 0; j < nrd && j < n_rd - r0; j++)
      chk(rl_addr[(r0+j)%64] == bm + 32'(4 * j), "R1 descriptor address",
          64'(rl_addr[(r0+j)%64]), 64'(bm + 32'(4 * j)));
    chk(done == exp_done, "R6 done", 64'(done), 64'(exp_done));
    chk(len_mismatch == (exp_done && extra != 0), "R6 length mismatch",
        64'(len_mismatch), 64'(exp_done && extra != 0));
    chk(err_overflow == exp_ovf, "R5 overflow flag", 64'(err_overflow), 64'(exp_ovf));
    chk(err_access == (err_read >= 0), "R9 access error flag", 64'(err_access), 64'(err_read >= 0));
    chk(irq == (exp_done && ien), "R8 irq gating", 64'(irq), 64'(exp_done && ien));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk({busy, seg_valid, mem_req, done, irq, len_mismatch, err_access, err_overflow} == 8'd0,
        "R11 reset state", 64'({busy, seg_valid, mem_req, done, irq, len_mismatch, err_access, err_overflow}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, seg_valid, mem_req, done, irq} == 5'd0, "R11 idle after reset",
        64'({busy, seg_valid, mem_req, done, irq}), 64'd0);

    for (int lp = -1; lp < MAXE; lp++)
      for (int p = 0; p < 3; p++)
        run_sg(lp, (p % 2 == 1) ? 32'h0000_0087 : 32'h8000_0045, (lp + p + 2) % 2, p != 1, -1, p, 1'b0);

    for (int er = 0; er < 6; er++)
      run_sg(2, (er % 2 == 1) ? 32'h0000_0087 : 32'h8000_0045, 0, 1'b1, er, er % 3, 1'b0);

    run_sg(1, 32'h8000_0045, 0, 1'b1, -1, 2, 1'b1);

    run_sg(0, 32'h0000_0087, 0, 1'b1, -1, 0, 1'b0);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(!done && !irq, "R10 done cleared by write-one", 64'({done, irq}), 64'd0);

    begin
      int s0, r0;
      s0 = n_seg;
      r0 = n_rd;
      rpat = 1;
      src_addr = 32'h8000_0047;
      src_len = 32'h8000_0123;
      cmd_data = 32'h0000_0200;
      cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      wait_idle();
      chk(n_seg - s0 == 1, "R7 direct single segment", 64'(n_seg - s0), 64'd1);
      chk(sl_addr[s0%64] == 32'h8000_0047, "R7 direct address unmasked", 64'(sl_addr[s0%64]), 64'h8000_0047);
      chk(sl_len[s0%64] == 31'h123, "R7 direct length", 64'(sl_len[s0%64]), 64'h123);
      chk(sl_last[s0%64] == 1'b1, "R7 direct last", 64'(sl_last[s0%64]), 64'd1);
      chk(n_rd == r0, "R7 no reads in direct mode", 64'(n_rd - r0), 64'd0);
      chk(done && !len_mismatch && irq, "R7 direct completion", 64'({done, len_mismatch, irq}), 64'b101);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule